// File: doc/BRIEF.md
# Cache-Line Request Splitter

This block sits between a requester that issues byte-addressed memory operations of any length and a memory path that accepts only accesses lying entirely inside one cache line. It accepts one request at a time (start address, byte count, and a read or write command) and issues a series of sub-requests. No sub-request crosses a line boundary. Each sub-request carries its own start address, its byte count, and the position of its first byte within the requester's data buffer.

Sub-requests leave over a valid/ready handshake in ascending address order, and the final one is flagged. Only the first and the last piece can be shorter than a full line. A request whose first and last byte fall in the same line (the last byte's line being `(addr + len - 1)` rounded down to the line size) leaves as one unchanged piece. A request of zero bytes produces no pieces and completes at once. A request with a command code that is neither read nor write is refused with an error pulse. The line size (a power of two of at least 2) and the address and length widths are parameters.

Top module: `line_splitter`

## Requirements
- R1: No sub-request crosses a multiple of `LINE_BYTES`: `(sub_addr mod LINE_BYTES) + sub_len <= LINE_BYTES`, and every sub-request that is not the last ends exactly on a line boundary.
- R2: A nonzero request whose first and last byte lie in the same line is issued as exactly one sub-request with the request's address and length, offset 0 and `sub_last` = 1.
- R3: `req_cmd` 2'b01 is read and 2'b10 is write, and `sub_write` is 1 for write and 0 for read. Codes 2'b00 and 2'b11 produce no sub-request and drive `err` high for exactly the one cycle after acceptance.
- R4: The `sub_offset` of each sub-request equals the sum of the `sub_len` values of the sub-requests issued before it within the same request. The first has offset 0.
- R5: The first sub-request's length is the smaller of `req_len` and `LINE_BYTES - (req_addr mod LINE_BYTES)`, and each later one is the smaller of the bytes left and `LINE_BYTES`.
- R6: Sub-requests are issued in ascending contiguous address order, starting at `req_addr`. `sub_last` is 1 only on the final one.
- R7: A valid read or write request with `req_len` = 0 produces no sub-request and raises `done` for the one cycle after acceptance.
- R8: `req_ready` is high only while the block is idle. A request presented while sub-requests are pending is not taken and does not disturb them.
- R9: While `sub_valid` is high and `sub_ready` is low, `sub_valid` and every sub-request field hold their values.
- R10: `done` is high for the single cycle after the final sub-request's handshake, and in that same cycle `sub_valid` is low and `req_ready` is high again.
- R11: Asserting `rst_n` low clears any pending work at once: `sub_valid`, `done` and `err` go low and `req_ready` goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request will be taken |
| req_addr | input | ADDR_W | Request start byte address |
| req_len | input | LEN_W | Request byte count |
| req_cmd | input | 2 | 01 read, 10 write, others invalid |
| sub_valid | output | 1 | Sub-request offered |
| sub_ready | input | 1 | Downstream takes the sub-request |
| sub_addr | output | ADDR_W | Sub-request start address |
| sub_len | output | $clog2(LINE_BYTES)+1 | Sub-request byte count |
| sub_offset | output | LEN_W | Byte offset into the requester's buffer |
| sub_write | output | 1 | 1 for write, 0 for read |
| sub_last | output | 1 | Final sub-request of the request |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle invalid-command pulse |

## Verification
Acceptance takes one register stage. The first sub-request, the zero-length `done` and the invalid-command `err` are all due in the cycle after the accepting edge. Each later sub-request follows the edge that took the one before it. `done` appears in the cycle after the last handshake and clears one cycle later. The bench drives inputs and samples outputs on the falling edge, so each check looks at the state left by the preceding rising edge. Where `sub_ready` is held low, the bench checks the same expected fields again on each stalled cycle.

// File: rtl/line_splitter_pkg.sv
package line_splitter_pkg;
  typedef enum logic [1:0] {
    CMD_NONE  = 2'b00,
    CMD_READ  = 2'b01,
    CMD_WRITE = 2'b10,
    CMD_RSVD  = 2'b11
  } cmd_e;

  typedef enum logic [0:0] {
    ST_IDLE  = 1'b0,
    ST_ISSUE = 1'b1
  } state_e;
endpackage

// File: rtl/line_chunk_calc.sv
module line_chunk_calc #(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 16,
  parameter int LINE_BYTES = 64,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int CHUNK_W   = OFF_W + 1
) (
  input  logic [ADDR_W-1:0]  cur_addr,
  input  logic [LEN_W-1:0]   remain,
  output logic [CHUNK_W-1:0] chunk_len,
  output logic               is_last
);
  logic [CHUNK_W-1:0] room;

  // Bytes from cur_addr up to the next line boundary (1..LINE_BYTES).
  assign room      = CHUNK_W'(LINE_BYTES) - {1'b0, cur_addr[OFF_W-1:0]};
  assign is_last   = remain <= LEN_W'(room);
  assign chunk_len = is_last ? CHUNK_W'(remain) : room;
endmodule

// File: rtl/line_split_ctrl.sv
module line_split_ctrl
  import line_splitter_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 16,
  parameter int LINE_BYTES = 64,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int CHUNK_W   = OFF_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [LEN_W-1:0]   req_len,
  input  logic [1:0]         req_cmd,
  input  logic               sub_ready,
  input  logic [CHUNK_W-1:0] chunk_len,
  input  logic               is_last,
  output logic               busy,
  output logic [ADDR_W-1:0]  cur_addr,
  output logic [LEN_W-1:0]   remain,
  output logic [LEN_W-1:0]   buf_off,
  output logic               is_write,
  output logic               done,
  output logic               err
);
  state_e            st_q, st_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [LEN_W-1:0]  rem_q, rem_d;
  logic [LEN_W-1:0]  off_q, off_d;
  logic              wr_q, wr_d;
  logic              done_q, done_d;
  logic              err_q, err_d;
  logic              cmd_ok;
  logic              take_req;
  logic              take_sub;
  logic              dp_en;

  assign cmd_ok   = (cmd_e'(req_cmd) == CMD_READ) || (cmd_e'(req_cmd) == CMD_WRITE);
  assign take_req = (st_q == ST_IDLE) && req_valid;
  assign take_sub = (st_q == ST_ISSUE) && sub_ready;
  assign dp_en    = take_req || take_sub;

  always_comb begin
    st_d   = st_q;
    addr_d = addr_q;
    rem_d  = rem_q;
    off_d  = off_q;
    wr_d   = wr_q;
    done_d = 1'b0;
    err_d  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          if (!cmd_ok) begin
            err_d = 1'b1;
          end else if (req_len == '0) begin
            done_d = 1'b1;
          end else begin
            st_d   = ST_ISSUE;
            addr_d = req_addr;
            rem_d  = req_len;
            off_d  = '0;
            wr_d   = (cmd_e'(req_cmd) == CMD_WRITE);
          end
        end
      end
      ST_ISSUE: begin
        if (sub_ready) begin
          addr_d = addr_q + ADDR_W'(chunk_len);
          rem_d  = rem_q - LEN_W'(chunk_len);
          off_d  = off_q + LEN_W'(chunk_len);
          if (is_last) begin
            st_d   = ST_IDLE;
            done_d = 1'b1;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      rem_q  <= '0;
      off_q  <= '0;
      wr_q   <= 1'b0;
    end else if (dp_en) begin
      addr_q <= addr_d;
      rem_q  <= rem_d;
      off_q  <= off_d;
      wr_q   <= wr_d;
    end
  end

  assign busy     = (st_q == ST_ISSUE);
  assign cur_addr = addr_q;
  assign remain   = rem_q;
  assign buf_off  = off_q;
  assign is_write = wr_q;
  assign done     = done_q;
  assign err      = err_q;

  // R9: a stalled sub-request keeps its fields
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !sub_ready |=> busy && $stable(cur_addr) && $stable(buf_off) && $stable(chunk_len));

  // R4: offset advances by the length just issued
  p_offset_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy && sub_ready && !is_last |=> buf_off == $past(buf_off) + LEN_W'($past(chunk_len)));

  // R10: completion follows the final handshake
  p_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy && sub_ready && is_last |=> done && !busy);

  // R7: zero-length request completes without issuing
  p_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && req_valid && cmd_ok && req_len == '0 |=> done && !busy);

  // R3: bad command raises err and issues nothing
  p_badcmd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && req_valid && !cmd_ok |=> err && !busy && !done);
endmodule

// File: rtl/line_splitter.sv
module line_splitter #(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 16,
  parameter int LINE_BYTES = 64,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int CHUNK_W   = OFF_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [LEN_W-1:0]   req_len,
  input  logic [1:0]         req_cmd,
  output logic               sub_valid,
  input  logic               sub_ready,
  output logic [ADDR_W-1:0]  sub_addr,
  output logic [CHUNK_W-1:0] sub_len,
  output logic [LEN_W-1:0]   sub_offset,
  output logic               sub_write,
  output logic               sub_last,
  output logic               done,
  output logic               err
);
  logic               busy;
  logic [ADDR_W-1:0]  cur_addr;
  logic [LEN_W-1:0]   remain;
  logic [LEN_W-1:0]   buf_off;
  logic               is_write;
  logic [CHUNK_W-1:0] chunk_len;
  logic               is_last;

  line_chunk_calc #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .LINE_BYTES(LINE_BYTES)
  ) u_calc (
    .cur_addr (cur_addr),
    .remain   (remain),
    .chunk_len(chunk_len),
    .is_last  (is_last)
  );

  line_split_ctrl #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .LINE_BYTES(LINE_BYTES)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_addr (req_addr),
    .req_len  (req_len),
    .req_cmd  (req_cmd),
    .sub_ready(sub_ready),
    .chunk_len(chunk_len),
    .is_last  (is_last),
    .busy     (busy),
    .cur_addr (cur_addr),
    .remain   (remain),
    .buf_off  (buf_off),
    .is_write (is_write),
    .done     (done),
    .err      (err)
  );

  assign req_ready  = !busy;
  assign sub_valid  = busy;
  assign sub_addr   = cur_addr;
  assign sub_len    = chunk_len;
  assign sub_offset = buf_off;
  assign sub_write  = is_write;
  assign sub_last   = busy && is_last;

  // R1: a piece never runs past its line
  p_no_cross_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sub_valid |-> ({1'b0, sub_addr[OFF_W-1:0]} + sub_len) <= CHUNK_W'(LINE_BYTES));

  // R1: a non-final piece ends on a boundary
  p_boundary_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sub_valid && !sub_last |-> OFF_W'(sub_addr[OFF_W-1:0] + OFF_W'(sub_len)) == '0);

  // R6: the next piece starts where the last one ended
  p_ascend_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sub_valid && sub_ready && !sub_last |=> sub_valid && sub_addr == $past(sub_addr) + ADDR_W'($past(sub_len)));

  // R5: pieces are never empty
  p_nonempty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sub_valid |-> sub_len != '0);
endmodule

// File: tb/tb_line_splitter.sv
`timescale 1ns/1ps
module tb_line_splitter;
  localparam int ADDR_W  = 32;
  localparam int LEN_W   = 16;
  localparam int LINE    = 16;
  localparam int CHUNK_W = $clog2(LINE) + 1;

  typedef struct packed {
    logic [ADDR_W-1:0] a;
    logic [LEN_W-1:0]  l;
    logic [1:0]        c;
    logic              stall;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{a: 32'h100, l: 16'd16, c: 2'b01, stall: 1'b0},
    '{a: 32'h105, l: 16'd4,  c: 2'b10, stall: 1'b1},
    '{a: 32'h10E, l: 16'd4,  c: 2'b01, stall: 1'b0},
    '{a: 32'h203, l: 16'd50, c: 2'b10, stall: 1'b1},
    '{a: 32'h300, l: 16'd48, c: 2'b01, stall: 1'b0},
    '{a: 32'h03F, l: 16'd1,  c: 2'b10, stall: 1'b0},
    '{a: 32'h40F, l: 16'd17, c: 2'b01, stall: 1'b1},
    '{a: 32'h500, l: 16'd0,  c: 2'b01, stall: 1'b0},
    '{a: 32'h600, l: 16'd8,  c: 2'b00, stall: 1'b0}
  };

  logic               clk = 1'b0;
  logic               rst_n;
  logic               req_valid;
  logic               req_ready;
  logic [ADDR_W-1:0]  req_addr;
  logic [LEN_W-1:0]   req_len;
  logic [1:0]         req_cmd;
  logic               sub_valid;
  logic               sub_ready;
  logic [ADDR_W-1:0]  sub_addr;
  logic [CHUNK_W-1:0] sub_len;
  logic [LEN_W-1:0]   sub_offset;
  logic               sub_write;
  logic               sub_last;
  logic               done;
  logic               err;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  line_splitter #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .LINE_BYTES(LINE)) dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_len(req_len), .req_cmd(req_cmd),
    .sub_valid(sub_valid), .sub_ready(sub_ready), .sub_addr(sub_addr),
    .sub_len(sub_len), .sub_offset(sub_offset), .sub_write(sub_write),
    .sub_last(sub_last), .done(done), .err(err)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_req(input vec_t v, input bit poke);
    longint ea, rem, off, nb, ch;
    int cyc;
    bit fin;
    @(negedge clk);
    req_addr = v.a; req_len = v.l; req_cmd = v.c; req_valid = 1'b1;
    chk(req_ready == 1'b1, "R8 idle ready", req_ready, 1);
    @(negedge clk);
    req_valid = 1'b0;
    if (v.c == 2'b00 || v.c == 2'b11) begin
      chk(err == 1'b1, "R3 err pulse", err, 1);
      chk(sub_valid == 1'b0, "R3 no sub", sub_valid, 0);
      @(negedge clk);
      chk(err == 1'b0, "R3 err one cycle", err, 0);
      return;
    end
    if (v.l == 0) begin
      chk(done == 1'b1, "R7 zero done", done, 1);
      chk(sub_valid == 1'b0, "R7 no sub", sub_valid, 0);
      @(negedge clk);
      chk(done == 1'b0, "R7 done one cycle", done, 0);
      return;
    end
    ea = v.a; rem = v.l; off = 0; cyc = 0; fin = 1'b0;
    while (!fin && cyc < 200) begin
      sub_ready = v.stall ? cyc[0] : 1'b1;
      if (poke) begin
        req_valid = 1'b1; req_addr = 32'hFFF0; req_len = 16'd3; req_cmd = 2'b10;
      end
      nb = (ea / LINE + 1) * LINE;
      ch = (rem < nb - ea) ? rem : nb - ea;
      chk(sub_valid == 1'b1, "R6 sub valid", sub_valid, 1);
      chk(req_ready == 1'b0, "R8 busy not ready", req_ready, 0);
      chk(sub_addr == ADDR_W'(ea), "R6 addr", sub_addr, ea);
      chk(sub_len == CHUNK_W'(ch), "R5 len", sub_len, ch);
      chk(sub_offset == LEN_W'(off), "R4 offset", sub_offset, off);
      chk(sub_write == (v.c == 2'b10), "R3 write flag", sub_write, v.c == 2'b10);
      chk(sub_last == (ch == rem), "R6 last flag", sub_last, ch == rem);
      if (v.l <= LINE && (v.a % LINE) + v.l <= LINE)
        chk(sub_len == CHUNK_W'(v.l) && sub_last && off == 0, "R2 single piece", sub_len, v.l);
      if (sub_ready) begin
        ea += ch; off += ch; rem -= ch;
        if (rem == 0) fin = 1'b1;
      end
      @(negedge clk);
      cyc++;
    end
    sub_ready = 1'b0;
    req_valid = 1'b0;
    chk(done == 1'b1, "R10 done", done, 1);
    chk(sub_valid == 1'b0, "R10 sub idle", sub_valid, 0);
    chk(req_ready == 1'b1, "R10 ready again", req_ready, 1);
    chk(off == v.l, "R1 total bytes", off, v.l);
    @(negedge clk);
    chk(done == 1'b0, "R10 done one cycle", done, 0);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_len = '0; req_cmd = 2'b00; sub_ready = 1'b0;
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1 && sub_valid == 1'b0, "R11 reset idle", {req_ready, sub_valid}, 2'b10);
    chk(done == 1'b0 && err == 1'b0, "R11 reset pulses", {done, err}, 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) do_req(VEC[i], 1'b0);

    // R3: reserved code 11 also refused
    do_req('{a: 32'h700, l: 16'd5, c: 2'b11, stall: 1'b0}, 1'b0);
    // R8: requests presented while busy are ignored
    do_req('{a: 32'h80A, l: 16'd30, c: 2'b10, stall: 1'b1}, 1'b1);
    // R1: long request over many lines
    do_req('{a: 32'h901, l: 16'd100, c: 2'b01, stall: 1'b0}, 1'b0);

    // R11: reset in the middle of a request
    @(negedge clk);
    req_addr = 32'hA00; req_len = 16'd40; req_cmd = 2'b01; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(sub_valid == 1'b1, "R11 busy before reset", sub_valid, 1);
    #1 rst_n = 1'b0;
    #0.5;
    chk(sub_valid == 1'b0 && req_ready == 1'b1, "R11 async clear", {sub_valid, req_ready}, 2'b01);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sub_valid == 1'b0 && done == 1'b0, "R11 stays idle", {sub_valid, done}, 0);
    do_req('{a: 32'hB0C, l: 16'd6, c: 2'b10, stall: 1'b0}, 1'b0);

    finished = 1'b1;
  end

  initial begin
    int t = 0;
    while (!finished && t < 100000) begin
      @(posedge clk);
      t++;
    end
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected done", t);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule